// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is an SMBus target that holds the configuration bytes of a differential clock fan-out buffer. It watches SCL and SDA with the system clock, recognises START, repeated START and STOP, and pulls SDA low through an open-drain enable when it must drive a zero. The held values leave the block as plain control pins for the clock-control logic: drive modes for power-down and stop, a loop-bandwidth select, a bypass/PLL select, a divide select, a per-output enable byte and a per-output stoppable byte.

A host writes with an indexed block transfer. It sends the start index, then the number of data bytes, then the data. A block read also begins with a write of the index. The host then issues a repeated START with the read address. The target answers first with the value of its writable count register and then with data bytes from the index onward. The index steps by one after every data byte. Two identification bytes are fixed and cannot be written. The data path is a two-wire serial bus, so there is no valid/ready stream: the host paces every bit with SCL, and the host's acknowledge bit is the only back-pressure a read has.

Top module: `smbcfg_target`

## Requirements
- R1: After reset the control pins are: power-down drive mode 0, stop drive mode 0, bandwidth select 1, PLL select 1, full-rate select 1, output enables 0xFF, stoppable mask 0x00; the count register is 0x07 and SDA is released.
- R2: The target acknowledges only the 7-bit address 0x6E (first byte 0xDC for write, 0xDD for read); for any other address it leaves SDA released (NACK) and ignores the bus until the next START.
- R3: A write is START, 0xDC, index N, count X, then X data bytes stored at N to N+X-1; the target acknowledges (SDA low during the 9th SCL pulse) the address, the index, the count and each stored byte.
- R4: A read is START, 0xDC, index N, repeated START, 0xDD; the target then sends the count register value, followed by the bytes at N, N+1 and onward, most significant bit first.
- R5: After each read byte the host ACK continues the read; a host NACK makes the target release SDA and send nothing more until the next START.
- R6: After the count byte a read returns as many register bytes as the count register holds; any further byte the host clocks reads 0xFF because SDA stays released.
- R7: Byte 4 reads {revision[3:0], vendor[3:0]} = 0x01 by default and byte 5 reads 0x83; writes to them are acknowledged and change nothing.
- R8: Byte 0 maps bit 7 = power-down drive mode, bit 6 = stop drive mode, bit 2 = bandwidth select, bit 1 = PLL select, bit 0 = full-rate select; bits 5:3 read 0 and ignore writes. Byte 3 and indices 7 and above read 0x00 and ignore writes, which are still acknowledged.
- R9: Byte 1 bit i enables output i, byte 2 bit i marks output i stoppable, byte 6 is the count register; all three are writable and read back what was written.
- R10: Data bytes beyond the count X of a write are not acknowledged and not stored.
- R11: A START or STOP at any point releases SDA and ends the transfer; bytes already acknowledged stay written.
- R12: The target changes the level it drives on SDA only while SCL is low, so its data bits are stable during every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pd_hiz_mode | output | 1 | Power-down drive mode (byte 0 bit 7) |
| stop_hiz_mode | output | 1 | Stop drive mode (byte 0 bit 6) |
| bw_sel | output | 1 | Loop bandwidth select (byte 0 bit 2) |
| pll_sel | output | 1 | 1 = PLL mode, 0 = fan-out bypass (byte 0 bit 1) |
| full_rate_sel | output | 1 | 1 = input rate, 0 = half rate (byte 0 bit 0) |
| out_enable | output | 8 | Per-output enable (byte 1) |
| stoppable | output | 8 | Per-output stoppable mask (byte 2) |

## Verification
The hardest states to reach are a START or STOP that lands in the middle of a byte, and a read clocked past the count register. From the ports these occur only when the host misbehaves. The bench drives SCL and SDA bit by bit with its own open-drain model, so it can cut a byte off after a few bits with a STOP or a repeated START, and it can keep acknowledging after the count is used up. A behavioural register model is compared with the control pins on every clock of each idle window. Read bits are sampled twice in each SCL high phase to catch an SDA change while SCL is high.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  localparam int BYTE_W = 8;
  localparam int BITCNT_W = $clog2(BYTE_W + 1);

  // register indices decoded by the engine's neighbour
  localparam logic [BYTE_W-1:0] IDX_MODE      = 8'd0;
  localparam logic [BYTE_W-1:0] IDX_OE        = 8'd1;
  localparam logic [BYTE_W-1:0] IDX_STOPPABLE = 8'd2;
  localparam logic [BYTE_W-1:0] IDX_IDENT     = 8'd4;
  localparam logic [BYTE_W-1:0] IDX_DEVICE    = 8'd5;
  localparam logic [BYTE_W-1:0] IDX_COUNT     = 8'd6;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK} eng_state_t;
  typedef enum logic [1:0] {K_ADDR, K_INDEX, K_COUNT, K_DATA} rx_kind_t;
endpackage

// File: rtl/smbcfg_line_sync.sv
module smbcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= scl_i;
          sda_p <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= {scl_p[STAGES-2:0], scl_i};
          sda_p <= {sda_p[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_p[LAST];
      sda_d <= sda_p[LAST];
    end
  end

  assign scl_s     = scl_p[LAST];
  assign sda_s     = sda_p[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbcfg_regfile.sv
module smbcfg_regfile
  import smbcfg_pkg::*;
#(
  parameter logic [3:0]        VENDOR_ID = 4'h1,
  parameter logic [3:0]        REV_ID    = 4'h0,
  parameter logic [BYTE_W-1:0] DEVICE_ID = 8'h83,
  parameter logic [BYTE_W-1:0] COUNT_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_count,
  output logic              pd_hiz_mode,
  output logic              stop_hiz_mode,
  output logic              bw_sel,
  output logic              pll_sel,
  output logic              full_rate_sel,
  output logic [BYTE_W-1:0] out_enable,
  output logic [BYTE_W-1:0] stoppable
);
  // only implemented mode bits are stored: {pd, stop, bw, pll, full_rate}
  localparam logic [4:0] MODE_RST = 5'b00111;

  logic [4:0]        mode_q;
  logic [BYTE_W-1:0] oe_q, stp_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      oe_q   <= '1;
      stp_q  <= '0;
      cnt_q  <= COUNT_RST;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_MODE:      mode_q <= {wr_data[7:6], wr_data[2:0]};
        IDX_OE:        oe_q   <= wr_data;
        IDX_STOPPABLE: stp_q  <= wr_data;
        IDX_COUNT:     cnt_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      IDX_MODE:      rd_data = {mode_q[4:3], 3'b000, mode_q[2:0]};
      IDX_OE:        rd_data = oe_q;
      IDX_STOPPABLE: rd_data = stp_q;
      IDX_IDENT:     rd_data = {REV_ID, VENDOR_ID};
      IDX_DEVICE:    rd_data = DEVICE_ID;
      IDX_COUNT:     rd_data = cnt_q;
      default:       rd_data = '0;
    endcase
  end

  assign rd_count      = cnt_q;
  assign pd_hiz_mode   = mode_q[4];
  assign stop_hiz_mode = mode_q[3];
  assign bw_sel        = mode_q[2];
  assign pll_sel       = mode_q[1];
  assign full_rate_sel = mode_q[0];
  assign out_enable    = oe_q;
  assign stoppable     = stp_q;

  AST_MODE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(wr_en && wr_idx == IDX_MODE)); // R8
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(wr_en && wr_idx == IDX_OE)); // R9
  AST_STP_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stp_q) |-> $past(wr_en && wr_idx == IDX_STOPPABLE)); // R9
  AST_CNT_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $past(wr_en && wr_idx == IDX_COUNT)); // R9
endmodule

// File: rtl/smbcfg_engine.sv
module smbcfg_engine
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] rd_count,
  output logic [BYTE_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

  eng_state_t          state_q;
  rx_kind_t            kind_q;
  logic [BITCNT_W-1:0] bitcnt_q;
  logic [BYTE_W-1:0]   shreg_q, index_q, wr_left_q, tx_left_q;
  logic                go_tx_q, host_ack_q, oe_q;

  logic              byte_done;
  logic [BYTE_W-1:0] tx_byte;

  assign byte_done = scl_fall && state_q == ST_RX && bitcnt_q == FULL;
  assign wr_en     = byte_done && kind_q == K_DATA && wr_left_q != '0;
  assign wr_idx    = index_q;
  assign wr_data   = shreg_q;
  assign rd_idx    = index_q;
  assign tx_byte   = (tx_left_q != '0) ? rd_data : '1;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      kind_q     <= K_ADDR;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      index_q    <= '0;
      wr_left_q  <= '0;
      tx_left_q  <= '0;
      go_tx_q    <= 1'b0;
      host_ack_q <= 1'b0;
      oe_q       <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_RX;
      kind_q   <= K_ADDR;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (state_q)
          ST_RX: begin
            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
          end
          ST_TX:   bitcnt_q <= bitcnt_q + 1'b1;
          ST_HACK: host_ack_q <= ~sda_s;
          default: ;
        endcase
      end
      if (scl_fall) begin
        case (state_q)
          ST_RX: begin
            if (bitcnt_q == FULL) begin
              bitcnt_q <= '0;
              go_tx_q  <= 1'b0;
              oe_q     <= 1'b1;
              state_q  <= ST_ACK;
              case (kind_q)
                K_ADDR: begin
                  kind_q  <= K_INDEX;
                  go_tx_q <= shreg_q[0];
                  if (shreg_q[BYTE_W-1:1] != ADDR7) begin
                    oe_q    <= 1'b0;
                    state_q <= ST_IDLE;
                  end
                end
                K_INDEX: begin
                  index_q <= shreg_q;
                  kind_q  <= K_COUNT;
                end
                K_COUNT: begin
                  wr_left_q <= shreg_q;
                  kind_q    <= K_DATA;
                end
                default: begin
                  if (wr_left_q != '0) begin
                    index_q   <= index_q + 1'b1;
                    wr_left_q <= wr_left_q - 1'b1;
                  end else begin
                    oe_q    <= 1'b0;
                    state_q <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            bitcnt_q <= '0;
            if (go_tx_q) begin
              state_q   <= ST_TX;
              oe_q      <= ~rd_count[BYTE_W-1];
              shreg_q   <= {rd_count[BYTE_W-2:0], 1'b1};
              tx_left_q <= rd_count;
            end else begin
              state_q <= ST_RX;
              oe_q    <= 1'b0;
            end
          end
          ST_TX: begin
            if (bitcnt_q == FULL) begin
              oe_q    <= 1'b0;
              state_q <= ST_HACK;
            end else begin
              oe_q    <= ~shreg_q[BYTE_W-1];
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
            end
          end
          ST_HACK: begin
            bitcnt_q <= '0;
            if (host_ack_q) begin
              state_q <= ST_TX;
              oe_q    <= ~tx_byte[BYTE_W-1];
              shreg_q <= {tx_byte[BYTE_W-2:0], 1'b1};
              if (tx_left_q != '0) begin
                index_q   <= index_q + 1'b1;
                tx_left_q <= tx_left_q - 1'b1;
              end
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R11
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R11
  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R12
  AST_HOST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HACK |-> !sda_oe); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> !sda_oe); // R2
endmodule

// File: rtl/smbcfg_target.sv
module smbcfg_target
  import smbcfg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [6:0]        ADDR7       = 7'h6E,
  parameter logic [3:0]        VENDOR_ID   = 4'h1,
  parameter logic [3:0]        REV_ID      = 4'h0,
  parameter logic [BYTE_W-1:0] DEVICE_ID   = 8'h83,
  parameter logic [BYTE_W-1:0] COUNT_RST   = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              pd_hiz_mode,
  output logic              stop_hiz_mode,
  output logic              bw_sel,
  output logic              pll_sel,
  output logic              full_rate_sel,
  output logic [BYTE_W-1:0] out_enable,
  output logic [BYTE_W-1:0] stoppable
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_idx, wr_data, rd_idx, rd_data, rd_count;

  smbcfg_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbcfg_engine #(.ADDR7(ADDR7)) i_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_count(rd_count), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  smbcfg_regfile #(
    .VENDOR_ID(VENDOR_ID), .REV_ID(REV_ID),
    .DEVICE_ID(DEVICE_ID), .COUNT_RST(COUNT_RST)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_count(rd_count),
    .pd_hiz_mode(pd_hiz_mode), .stop_hiz_mode(stop_hiz_mode), .bw_sel(bw_sel),
    .pll_sel(pll_sel), .full_rate_sel(full_rate_sel),
    .out_enable(out_enable), .stoppable(stoppable)
  );
endmodule

// File: tb/test_smbcfg_target.sv
module test_smbcfg_target;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl_drv = 1'b1, host_low = 1'b0;
  logic sda_line;
  logic sda_oe, pd_hiz_mode, stop_hiz_mode, bw_sel, pll_sel, full_rate_sel;
  logic [7:0] out_enable, stoppable;

  assign sda_line = !(host_low || sda_oe);

  smbcfg_target i_smbcfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .pd_hiz_mode(pd_hiz_mode), .stop_hiz_mode(stop_hiz_mode), .bw_sel(bw_sel),
    .pll_sel(pll_sel), .full_rate_sel(full_rate_sel),
    .out_enable(out_enable), .stoppable(stoppable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit settled = 0, win_bad = 0, done = 0;
  string cur_req = "R1";
  int mreg[256];
  bit glitch;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mread(int idx);
    return mreg[idx & 255];
  endfunction

  function automatic void mwrite(int idx, int v);
    case (idx & 255)
      0: mreg[0] = v & 'hC7;
      1, 2, 6: mreg[idx & 255] = v & 'hFF;
      default: ;
    endcase
  endfunction

  // reference comparison on every clock of an idle window
  always @(negedge clk) begin
    if (settled && !win_bad) begin
      if ({pd_hiz_mode, stop_hiz_mode, 3'b000, bw_sel, pll_sel, full_rate_sel} != 8'(mreg[0])) begin
        win_bad = 1;
        $display("FAIL %s mode byte actual=%0h expected=%0h", cur_req,
          {pd_hiz_mode, stop_hiz_mode, 3'b000, bw_sel, pll_sel, full_rate_sel}, mreg[0]);
      end else if (out_enable != 8'(mreg[1]) || stoppable != 8'(mreg[2])) begin
        win_bad = 1;
        $display("FAIL %s enable/stoppable actual=%0h/%0h expected=%0h/%0h", cur_req,
          out_enable, stoppable, mreg[1], mreg[2]);
      end else if (sda_line !== 1'b1) begin
        win_bad = 1;
        $display("FAIL %s idle sda actual=%0b expected=1", cur_req, sda_line);
      end
    end
  end

  task automatic settle(string req);
    cur_req = req;
    settled = 1;
    repeat (20) @(negedge clk);
    settled = 0;
    n_checks++;
    if (win_bad) n_fail++;
    win_bad = 0;
  endtask

  task automatic wait_q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 0; wait_q();
    scl_drv = 1; wait_q();
    host_low = 1; wait_q();
    scl_drv = 0; wait_q();
  endtask

  task automatic bus_stop();
    host_low = 1; wait_q();
    scl_drv = 1; wait_q();
    host_low = 0; wait_q();
  endtask

  task automatic send_bit(bit b);
    host_low = !b; wait_q();
    scl_drv = 1; wait_q(); wait_q();
    scl_drv = 0; wait_q();
  endtask

  task automatic recv_bit(output bit b);
    bit early;
    host_low = 0; wait_q();
    scl_drv = 1;
    repeat (3) @(negedge clk);
    early = sda_line;
    repeat (2*QTR - 6) @(negedge clk);
    b = sda_line;
    if (early != b) glitch = 1;
    repeat (3) @(negedge clk);
    scl_drv = 0; wait_q();
  endtask

  task automatic send_byte(int v, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = !a;
  endtask

  task automatic recv_byte(output int v, input bit ack);
    bit b;
    v = 0;
    for (int i = 0; i < 8; i++) begin
      recv_bit(b);
      v = (v << 1) | int'(b);
    end
    send_bit(!ack);
  endtask

  task automatic wr_block(int idx, int cnt, int data[$], string req);
    bit ack;
    bus_start();
    send_byte('hDC, ack); check("R3", ack, 1);
    send_byte(idx, ack);  check("R3", ack, 1);
    send_byte(cnt, ack);  check("R3", ack, 1);
    for (int i = 0; i < data.size(); i++) begin
      send_byte(data[i], ack);
      check(i < cnt ? req : "R10", ack, i < cnt ? 1 : 0);
      if (i < cnt) mwrite(idx + i, data[i]);
      else break;
    end
    bus_stop();
    settle(req);
  endtask

  task automatic rd_block(int idx, int nread, string req);
    bit ack;
    int v;
    glitch = 0;
    bus_start();
    send_byte('hDC, ack); check("R4", ack, 1);
    send_byte(idx, ack);  check("R4", ack, 1);
    bus_start();
    send_byte('hDD, ack); check("R4", ack, 1);
    recv_byte(v, 1);      check("R4", v, mreg[6]);
    for (int i = 0; i < nread; i++) begin
      recv_byte(v, i < nread - 1);
      check(req, v, i < mreg[6] ? mread(idx + i) : 'hFF);
    end
    bus_stop();
    check("R12", int'(glitch), 0);
    settle(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all) actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    int v;
    for (int i = 0; i < 256; i++) mreg[i] = 0;
    mreg[0] = 'h07; mreg[1] = 'hFF; mreg[4] = 'h01; mreg[5] = 'h83; mreg[6] = 'h07;

    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset values
    check("R1", {pd_hiz_mode, stop_hiz_mode, bw_sel, pll_sel, full_rate_sel}, 'b00111);
    check("R1", out_enable, 'hFF);
    check("R1", stoppable, 'h00);
    check("R1", sda_line, 1);
    settle("R1");

    // R4 full read from index 0 with reset count; R7 identity bytes
    rd_block(0, 7, "R4");
    rd_block(4, 2, "R7");

    // R3 block write and read back, R9 enable/stoppable bytes
    wr_block(1, 2, '{'hA5, 'h3C}, "R3");
    rd_block(1, 2, "R9");

    // R8 mode byte with reserved bits
    wr_block(0, 1, '{'hFF}, "R8");
    rd_block(0, 1, "R8");
    wr_block(0, 1, '{'h40}, "R8");

    // R7 writes to reserved / identity ignored but acknowledged
    wr_block(3, 3, '{'h11, 'h22, 'h33}, "R7");
    rd_block(3, 3, "R7");

    // R6 count register limits read length
    wr_block(6, 1, '{'h03}, "R9");
    rd_block(1, 5, "R6");

    // R8 indices 7 and above
    wr_block(7, 2, '{'h5A, 'h5A}, "R8");
    rd_block(6, 3, "R8");

    // R10 byte past write count
    wr_block(2, 1, '{'hF0, 'h0F}, "R10");

    // R2 foreign address
    bus_start();
    send_byte('hB4, ack); check("R2", ack, 0);
    send_byte('h01, ack); check("R2", ack, 0);
    send_byte('h00, ack); check("R2", ack, 0);
    bus_stop();
    settle("R2");

    // R5 host NACK ends the read
    bus_start();
    send_byte('hDC, ack); check("R5", ack, 1);
    send_byte(1, ack);    check("R5", ack, 1);
    bus_start();
    send_byte('hDD, ack); check("R5", ack, 1);
    recv_byte(v, 1);      check("R5", v, mreg[6]);
    recv_byte(v, 0);      check("R5", v, mreg[1]);
    recv_byte(v, 0);      check("R5", v, 'hFF);
    bus_stop();
    settle("R5");

    // R11 STOP in the middle of a data byte
    bus_start();
    send_byte('hDC, ack);
    send_byte(1, ack);
    send_byte(2, ack);
    send_byte('h12, ack); check("R11", ack, 1);
    mwrite(1, 'h12);
    send_bit(0); send_bit(1); send_bit(1);
    bus_stop();
    settle("R11");

    // R11 repeated START in the middle of a data byte
    bus_start();
    send_byte('hDC, ack);
    send_byte(2, ack);
    send_byte(1, ack);
    send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    bus_start();
    send_byte('hDC, ack); check("R11", ack, 1);
    send_byte(2, ack);
    send_byte(1, ack);
    send_byte('h77, ack); check("R11", ack, 1);
    mwrite(2, 'h77);
    bus_stop();
    settle("R11");
    rd_block(1, 2, "R11");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule